// File: doc/BRIEF.md
# Queue Doorbell Write Decoder

This block sits on the register write path of a queue-based storage controller and turns each store into the doorbell window into a pointer update for one queue. Every write at or above the window base is taken as either a new submission tail or a new completion head. The word offset inside the window picks which kind it is and which queue it targets. The write is checked for alignment, for a queue that exists, and for a value that fits that queue's depth. A write that passes is stored, and it raises one-cycle request pulses that the fetch engine, the completion poster and the interrupt logic consume.

The decoder keeps a small table for each queue: whether the queue exists, its depth, the completion queue a submission queue feeds, the submission tail, and the completion head and tail. The queue-management logic loads this table through a configuration strobe. The completion poster advances the completion tail through its own strobe. The fetch and posting engines read the stored pointers back through a queue-indexed read port. Queue 0 exists on both sides for as long as the controller is enabled. Dropping the enable clears every queue and pointer.

Top module: `dbell_decoder`

## Requirements
- R1: A write with an address below the doorbell base (0x1000) changes no stored pointer and raises no request.
- R2: A write in the doorbell window whose address has either of bits [1:0] set is ignored: no pointer changes and no request is raised.
- R3: With off = address − 0x1000, off bit 2 clear selects the submission tail of queue off>>3, and off bit 2 set selects the completion head of queue (address − 0x1004)>>3.
- R4: Only data bits [15:0] form the new pointer value. Bits [31:16] have no effect.
- R5: A write to a queue id of NUM_Q or more, or to a queue that was never created (or was deleted), is ignored. Queue 0 of both kinds is valid from the cycle after the enable rises.
- R6: A pointer value greater than or equal to the target queue's depth is ignored.
- R7: An accepted submission-tail write stores the value and, one cycle after the write edge, pulses the fetch request bit for that queue alone.
- R8: An accepted completion-head write stores the value. If that completion queue was full before the write ((tail+1) mod depth == head), the same cycle pulses the post request for that queue and the fetch request for every existing submission queue bound to it.
- R9: After an accepted completion-head write, the interrupt request bit for that queue pulses if the completion tail differs from the new head. At most one interrupt bit is set in any cycle.
- R10: Each completion-tail advance strobe moves that queue's tail by one and wraps it to 0 at the queue's depth.
- R11: While the controller enable is low, every queue reads as absent and all stored pointers read as zero. Doorbell writes during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlEnable | input | 1 | Controller enabled; low clears all queues |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | AW | Register write byte address |
| wrData | input | 32 | Register write data |
| cfgWr | input | 1 | Queue table load strobe |
| cfgIsCq | input | 1 | Table load targets a completion queue (1) or a submission queue (0) |
| cfgQid | input | QW | Queue id for the table load |
| cfgCreate | input | 1 | 1 creates the queue and clears its pointers, 0 deletes it |
| cfgSize | input | PW | Queue depth in entries |
| cfgBindCq | input | QW | Completion queue fed by the submission queue being created |
| cqTailAdv | input | 1 | Completion poster wrote one entry |
| cqTailQid | input | QW | Queue whose completion tail advances |
| rdQid | input | QW | Queue id for pointer readback |
| rdSqTail | output | PW | Stored submission tail of rdQid |
| rdCqHead | output | PW | Stored completion head of rdQid |
| rdCqTail | output | PW | Completion tail of rdQid |
| sqFetchReq | output | NUM_Q | One-cycle fetch request per submission queue |
| cqPostReq | output | NUM_Q | One-cycle post request per completion queue |
| irqReq | output | NUM_Q | One-cycle interrupt request per completion queue |

## Verification
The assertions assume that a completion-tail advance, a table load and a doorbell write never target the same queue in the same cycle. They also assume that the enable does not fall in a cycle that carries an accepted write, and that every depth loaded is at least two. The stimulus keeps to these limits because it issues one operation at a time, each held for one full clock, and creates queues only with depths of three or more. The stimulus also covers ignored writes: below the base, misaligned, out of range, to an absent queue, and too large. It covers the completion-full wake-up with two bound submission queues and a tail that has wrapped.

// File: rtl/qdb_pkg.sv
package qdb_pkg;

  // Strobes from the decode control into the queue state datapath.
  typedef struct packed {
    logic sqTailWr;   // store wrPtr as submission tail of wrQid
    logic cqHeadWr;   // store wrPtr as completion head of wrQid
  } dbStrobe_t;

  // Doorbell value field width (data bits used as the pointer)
  localparam int DB_VAL_W = 16;

endpackage

// File: rtl/qdb_state.sv
module qdb_state
  import qdb_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int QW    = 2,
  parameter int PW    = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ctrlEnable,
  input  dbStrobe_t                  strobe,
  input  logic [QW-1:0]              wrQid,
  input  logic [PW-1:0]              wrPtr,
  input  logic                       cfgWr,
  input  logic                       cfgIsCq,
  input  logic [QW-1:0]              cfgQid,
  input  logic                       cfgCreate,
  input  logic [PW-1:0]              cfgSize,
  input  logic [QW-1:0]              cfgBindCq,
  input  logic                       cqTailAdv,
  input  logic [QW-1:0]              cqTailQid,
  input  logic [QW-1:0]              rdQid,
  output logic [NUM_Q-1:0]           sqOk,
  output logic [NUM_Q-1:0]           cqOk,
  output logic [NUM_Q-1:0][PW-1:0]   sqSize,
  output logic [NUM_Q-1:0][PW-1:0]   cqSize,
  output logic [NUM_Q-1:0][PW-1:0]   cqHead,
  output logic [NUM_Q-1:0][PW-1:0]   cqTail,
  output logic [NUM_Q-1:0][QW-1:0]   sqBind,
  output logic [PW-1:0]              rdSqTail,
  output logic [PW-1:0]              rdCqHead,
  output logic [PW-1:0]              rdCqTail
);

  logic [NUM_Q-1:0]         sqMade, cqMade;
  logic [NUM_Q-1:0][PW-1:0] sqSz, cqSz, sqTl, cqHd, cqTl;
  logic [NUM_Q-1:0][QW-1:0] sqCq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqMade <= '0;
      cqMade <= '0;
      sqSz   <= '0;
      cqSz   <= '0;
      sqTl   <= '0;
      cqHd   <= '0;
      cqTl   <= '0;
      sqCq   <= '0;
    end else if (!ctrlEnable) begin
      sqMade <= '0;
      cqMade <= '0;
      sqTl   <= '0;
      cqHd   <= '0;
      cqTl   <= '0;
    end else begin
      // queue 0 of both kinds exists while enabled
      sqMade[0] <= 1'b1;
      cqMade[0] <= 1'b1;
      for (int q = 0; q < NUM_Q; q++) begin
        if (cfgWr && cfgQid == QW'(q)) begin
          if (cfgIsCq) begin
            if (q != 0) cqMade[q] <= cfgCreate;
            if (cfgCreate || q == 0) begin
              cqSz[q] <= cfgSize;
              cqHd[q] <= '0;
              cqTl[q] <= '0;
            end
          end else begin
            if (q != 0) sqMade[q] <= cfgCreate;
            if (cfgCreate || q == 0) begin
              sqSz[q] <= cfgSize;
              sqTl[q] <= '0;
              if (q != 0) sqCq[q] <= cfgBindCq;
            end
          end
        end
        if (strobe.sqTailWr && wrQid == QW'(q)) sqTl[q] <= wrPtr;
        if (strobe.cqHeadWr && wrQid == QW'(q)) cqHd[q] <= wrPtr;
        if (cqTailAdv && cqTailQid == QW'(q)) begin
          if (cqTl[q] + PW'(1) == cqSz[q]) cqTl[q] <= '0;
          else                             cqTl[q] <= cqTl[q] + PW'(1);
        end
      end
    end
  end

  assign sqOk   = sqMade;
  assign cqOk   = cqMade;
  assign sqSize = sqSz;
  assign cqSize = cqSz;
  assign cqHead = cqHd;
  assign cqTail = cqTl;
  assign sqBind = sqCq;

  assign rdSqTail = sqTl[rdQid];
  assign rdCqHead = cqHd[rdQid];
  assign rdCqTail = cqTl[rdQid];

  // R7
  sq_tail_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sqTailWr && ctrlEnable) |=> sqTl[$past(wrQid)] == $past(wrPtr));

  // R8
  cq_head_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cqHeadWr && ctrlEnable) |=> cqHd[$past(wrQid)] == $past(wrPtr));

  // R10
  cq_tail_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cqTailAdv && ctrlEnable && !cfgWr && cqTl[cqTailQid] + PW'(1) == cqSz[cqTailQid])
      |=> cqTl[$past(cqTailQid)] == '0);

  // R11
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEnable |=> (sqMade == '0 && cqMade == '0 && sqTl == '0 && cqHd == '0));

endmodule

// File: rtl/qdb_ctrl.sv
module qdb_ctrl
  import qdb_pkg::*;
#(
  parameter int          NUM_Q   = 4,
  parameter int          QW      = 2,
  parameter int          PW      = 16,
  parameter int          AW      = 16,
  parameter logic [31:0] DB_BASE = 32'h1000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [AW-1:0]              wrAddr,
  input  logic [31:0]                wrData,
  input  logic [NUM_Q-1:0]           sqOk,
  input  logic [NUM_Q-1:0]           cqOk,
  input  logic [NUM_Q-1:0][PW-1:0]   sqSize,
  input  logic [NUM_Q-1:0][PW-1:0]   cqSize,
  input  logic [NUM_Q-1:0][PW-1:0]   cqHead,
  input  logic [NUM_Q-1:0][PW-1:0]   cqTail,
  input  logic [NUM_Q-1:0][QW-1:0]   sqBind,
  output dbStrobe_t                  strobe,
  output logic [QW-1:0]              wrQid,
  output logic [PW-1:0]              wrPtr,
  output logic [NUM_Q-1:0]           sqFetchReq,
  output logic [NUM_Q-1:0]           cqPostReq,
  output logic [NUM_Q-1:0]           irqReq
);

  localparam logic [AW-1:0] BASE_A = AW'(DB_BASE);
  localparam int            QIDW   = AW - 3;

  logic [AW-1:0]       offset;
  logic [QIDW-1:0]     qidWide;
  logic                inWindow, aligned, isCqKind, inRange;
  logic [DB_VAL_W-1:0] newVal;
  logic                sqFits, cqFits, sqAccept, cqAccept;
  logic [PW-1:0]       tailInc, tailNext;
  logic                cqWasFull;
  logic [NUM_Q-1:0]    qidHot, boundMask;
  logic                unusedDataHi;

  assign offset    = wrAddr - BASE_A;
  assign inWindow  = wrAddr >= BASE_A;
  assign aligned   = wrAddr[1:0] == 2'b00;
  assign isCqKind  = offset[2];
  assign qidWide   = offset[AW-1:3];
  assign inRange   = qidWide < QIDW'(NUM_Q);
  assign wrQid     = qidWide[QW-1:0];
  assign newVal    = wrData[DB_VAL_W-1:0];
  assign wrPtr     = newVal[PW-1:0];
  assign unusedDataHi = ^wrData[31:DB_VAL_W];

  assign sqFits = 32'(newVal) < 32'(sqSize[wrQid]);
  assign cqFits = 32'(newVal) < 32'(cqSize[wrQid]);

  assign sqAccept = wrEn && inWindow && aligned && !isCqKind && inRange
                    && sqOk[wrQid] && sqFits;
  assign cqAccept = wrEn && inWindow && aligned && isCqKind && inRange
                    && cqOk[wrQid] && cqFits;

  assign strobe.sqTailWr = sqAccept;
  assign strobe.cqHeadWr = cqAccept;

  // fullness seen before the head moves
  assign tailInc   = cqTail[wrQid] + PW'(1);
  assign tailNext  = (tailInc == cqSize[wrQid]) ? '0 : tailInc;
  assign cqWasFull = tailNext == cqHead[wrQid];

  assign qidHot = NUM_Q'(1) << wrQid;

  for (genvar s = 0; s < NUM_Q; s++) begin : g_bind
    assign boundMask[s] = sqOk[s] && (sqBind[s] == wrQid);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqFetchReq <= '0;
      cqPostReq  <= '0;
      irqReq     <= '0;
    end else begin
      sqFetchReq <= '0;
      cqPostReq  <= '0;
      irqReq     <= '0;
      if (sqAccept) begin
        sqFetchReq <= qidHot;
      end else if (cqAccept) begin
        if (cqWasFull) begin
          sqFetchReq <= boundMask;
          cqPostReq  <= qidHot;
        end
        if (wrPtr != cqTail[wrQid]) irqReq <= qidHot;
      end
    end
  end

  // R1
  below_base_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr < BASE_A) |=> (sqFetchReq == '0 && cqPostReq == '0 && irqReq == '0));

  // R2
  misaligned_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr[1:0] != 2'b00) |=> (sqFetchReq == '0 && cqPostReq == '0 && irqReq == '0));

  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqReq));

  // R8
  post_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (cqPostReq == '0 && irqReq == '0));

  // R7
  sq_fetch_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrAddr[2]) |=> $onehot0(sqFetchReq));

endmodule

// File: rtl/dbell_decoder.sv
module dbell_decoder
  import qdb_pkg::*;
#(
  parameter int          NUM_Q   = 4,
  parameter int          PW      = 16,
  parameter int          AW      = 16,
  parameter logic [31:0] DB_BASE = 32'h1000,
  localparam int         QW      = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlEnable,
  input  logic               wrEn,
  input  logic [AW-1:0]      wrAddr,
  input  logic [31:0]        wrData,
  input  logic               cfgWr,
  input  logic               cfgIsCq,
  input  logic [QW-1:0]      cfgQid,
  input  logic               cfgCreate,
  input  logic [PW-1:0]      cfgSize,
  input  logic [QW-1:0]      cfgBindCq,
  input  logic               cqTailAdv,
  input  logic [QW-1:0]      cqTailQid,
  input  logic [QW-1:0]      rdQid,
  output logic [PW-1:0]      rdSqTail,
  output logic [PW-1:0]      rdCqHead,
  output logic [PW-1:0]      rdCqTail,
  output logic [NUM_Q-1:0]   sqFetchReq,
  output logic [NUM_Q-1:0]   cqPostReq,
  output logic [NUM_Q-1:0]   irqReq
);

  dbStrobe_t                strobe;
  logic [QW-1:0]            wrQid;
  logic [PW-1:0]            wrPtr;
  logic [NUM_Q-1:0]         sqOk, cqOk;
  logic [NUM_Q-1:0][PW-1:0] sqSize, cqSize, cqHead, cqTail;
  logic [NUM_Q-1:0][QW-1:0] sqBind;

  qdb_ctrl #(
    .NUM_Q(NUM_Q), .QW(QW), .PW(PW), .AW(AW), .DB_BASE(DB_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sqOk(sqOk), .cqOk(cqOk), .sqSize(sqSize), .cqSize(cqSize),
    .cqHead(cqHead), .cqTail(cqTail), .sqBind(sqBind),
    .strobe(strobe), .wrQid(wrQid), .wrPtr(wrPtr),
    .sqFetchReq(sqFetchReq), .cqPostReq(cqPostReq), .irqReq(irqReq)
  );

  qdb_state #(
    .NUM_Q(NUM_Q), .QW(QW), .PW(PW)
  ) u_state (
    .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable),
    .strobe(strobe), .wrQid(wrQid), .wrPtr(wrPtr),
    .cfgWr(cfgWr), .cfgIsCq(cfgIsCq), .cfgQid(cfgQid), .cfgCreate(cfgCreate),
    .cfgSize(cfgSize), .cfgBindCq(cfgBindCq),
    .cqTailAdv(cqTailAdv), .cqTailQid(cqTailQid), .rdQid(rdQid),
    .sqOk(sqOk), .cqOk(cqOk), .sqSize(sqSize), .cqSize(cqSize),
    .cqHead(cqHead), .cqTail(cqTail), .sqBind(sqBind),
    .rdSqTail(rdSqTail), .rdCqHead(rdCqHead), .rdCqTail(rdCqTail)
  );

endmodule

// File: tb/dbell_decoder_test.sv
module dbell_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlEnable = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        cfgWr = 1'b0, cfgIsCq = 1'b0, cfgCreate = 1'b0;
  logic [1:0]  cfgQid = '0, cfgBindCq = '0, cqTailQid = '0, rdQid = '0;
  logic [15:0] cfgSize = '0;
  logic        cqTailAdv = 1'b0;
  logic [15:0] rdSqTail, rdCqHead, rdCqTail;
  logic [3:0]  sqFetchReq, cqPostReq, irqReq;

  int testsRun = 0;
  int testsFailed = 0;
  bit doneFlag = 0;

  typedef struct {
    logic [3:0] fetch;
    logic [3:0] post;
    logic [3:0] irq;
    string      tag;
  } evt_t;
  evt_t expQ[$];

  // reference model of the queue table
  bit okS[NQ], okC[NQ];
  int szS[NQ], szC[NQ], mTail[NQ], mHead[NQ], mCqTail[NQ], mBind[NQ];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbell_decoder uut (
    .clk(clk), .rstN(rstN), .ctrlEnable(ctrlEnable),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfgWr(cfgWr), .cfgIsCq(cfgIsCq), .cfgQid(cfgQid), .cfgCreate(cfgCreate),
    .cfgSize(cfgSize), .cfgBindCq(cfgBindCq),
    .cqTailAdv(cqTailAdv), .cqTailQid(cqTailQid), .rdQid(rdQid),
    .rdSqTail(rdSqTail), .rdCqHead(rdCqHead), .rdCqTail(rdCqTail),
    .sqFetchReq(sqFetchReq), .cqPostReq(cqPostReq), .irqReq(irqReq)
  );

  task automatic check(input string tag, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  // monitor: compares events from each write edge against the scoreboard
  always @(posedge clk) begin
    if (wrEn) begin
      #1;
      if (expQ.size() > 0) begin
        evt_t e;
        e = expQ.pop_front();
        check({e.tag, " fetch"}, int'(sqFetchReq), int'(e.fetch));
        check({e.tag, " post"},  int'(cqPostReq),  int'(e.post));
        check({e.tag, " irq"},   int'(irqReq),     int'(e.irq));
      end
    end
  end

  task automatic dbWrite(input logic [15:0] addr, input logic [31:0] data, input string tag);
    evt_t e;
    int off, q, v;
    bit isCq, full;
    e.fetch = '0; e.post = '0; e.irq = '0; e.tag = tag;
    if (ctrlEnable && addr >= 16'h1000 && addr[1:0] == 2'b00) begin
      off  = int'(addr) - 'h1000;
      isCq = ((off >> 2) & 1) == 1;
      q    = off >> 3;
      v    = int'(data[15:0]);
      if (q < NQ) begin
        if (!isCq && okS[q] && v < szS[q]) begin
          mTail[q] = v;
          e.fetch  = 4'(1 << q);
        end else if (isCq && okC[q] && v < szC[q]) begin
          full = ((mCqTail[q] + 1) % szC[q]) == mHead[q];
          mHead[q] = v;
          if (full) begin
            for (int s = 0; s < NQ; s++)
              if (okS[s] && mBind[s] == q) e.fetch[s] = 1'b1;
            e.post = 4'(1 << q);
          end
          if (v != mCqTail[q]) e.irq = 4'(1 << q);
        end
      end
    end
    expQ.push_back(e);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cfgQueue(input bit isCq, input int q, input bit create,
                          input int size, input int bindCq);
    @(negedge clk);
    cfgWr = 1'b1; cfgIsCq = isCq; cfgQid = 2'(q); cfgCreate = create;
    cfgSize = 16'(size); cfgBindCq = 2'(bindCq);
    @(negedge clk);
    cfgWr = 1'b0;
    if (isCq) begin
      if (q != 0) okC[q] = create;
      if (create || q == 0) begin szC[q] = size; mHead[q] = 0; mCqTail[q] = 0; end
    end else begin
      if (q != 0) okS[q] = create;
      if (create || q == 0) begin
        szS[q] = size; mTail[q] = 0;
        if (q != 0) mBind[q] = bindCq;
      end
    end
  endtask

  task automatic advTail(input int q);
    @(negedge clk);
    cqTailAdv = 1'b1; cqTailQid = 2'(q);
    @(negedge clk);
    cqTailAdv = 1'b0;
    mCqTail[q] = (mCqTail[q] + 1) % szC[q];
  endtask

  task automatic readBack(input int q, input string tag);
    rdQid = 2'(q);
    #1;
    check({tag, " sqTail"}, int'(rdSqTail), mTail[q]);
    check({tag, " cqHead"}, int'(rdCqHead), mHead[q]);
    check({tag, " cqTail"}, int'(rdCqTail), mCqTail[q]);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin
      okS[q] = 0; okC[q] = 0; szS[q] = 0; szC[q] = 0;
      mTail[q] = 0; mHead[q] = 0; mCqTail[q] = 0; mBind[q] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check("reset fetch", int'(sqFetchReq), 0);
    check("reset post", int'(cqPostReq), 0);
    check("reset irq", int'(irqReq), 0);
    readBack(0, "reset");

    ctrlEnable = 1'b1;
    @(negedge clk);
    okS[0] = 1; okC[0] = 1;
    cfgQueue(0, 0, 1, 4, 0);   // admin submission depth 4
    cfgQueue(1, 0, 1, 4, 0);   // admin completion depth 4
    cfgQueue(1, 1, 1, 3, 0);   // CQ1 depth 3
    cfgQueue(0, 1, 1, 8, 1);   // SQ1 depth 8 -> CQ1
    cfgQueue(0, 2, 1, 4, 1);   // SQ2 depth 4 -> CQ1

    // R5 R7 queue 0 valid after enable, tail stored and fetch pulsed
    dbWrite(16'h1000, 32'h2, "R7 sq0 tail");
    readBack(0, "R7 sq0");
    // R3 R4 queue 1 submission slot, high data bits dropped
    dbWrite(16'h1008, 32'hABCD_0005, "R4 sq1 tail high bits");
    readBack(1, "R4 sq1");
    // R6 value equal to depth ignored
    dbWrite(16'h1008, 32'h8, "R6 sq1 too large");
    readBack(1, "R6 sq1");
    // R2 misaligned
    dbWrite(16'h1009, 32'h1, "R2 misaligned");
    dbWrite(16'h100A, 32'h1, "R2 misaligned half");
    readBack(1, "R2 sq1");
    // R1 below base
    dbWrite(16'h0008, 32'h1, "R1 below base");
    readBack(1, "R1 sq1");
    // R5 absent queue and out of range
    dbWrite(16'h1018, 32'h1, "R5 sq3 absent");
    dbWrite(16'h1014, 32'h1, "R5 cq2 absent");
    dbWrite(16'h1020, 32'h1, "R5 out of range");
    readBack(3, "R5 q3");

    // R8 R9 fill CQ1 (depth 3): tail 2, head 0 -> full
    advTail(1);
    advTail(1);
    readBack(1, "R10 cq1 tail");
    dbWrite(16'h100C, 32'h1, "R8 cq1 head full wake");
    readBack(1, "R8 cq1");
    // R9 head catches up with tail: no irq, not full
    dbWrite(16'h100C, 32'h2, "R9 cq1 head equals tail");
    readBack(1, "R9 cq1");

    // R10 wrap on CQ0 (depth 4), then full wake of SQ0
    dbWrite(16'h1004, 32'h1, "R9 cq0 head irq");
    advTail(0); advTail(0); advTail(0); advTail(0);
    readBack(0, "R10 cq0 wrapped");
    dbWrite(16'h1004, 32'h2, "R8 cq0 full wake");
    readBack(0, "R8 cq0");

    // R5 deleted queue ignored
    cfgQueue(0, 2, 0, 4, 1);
    dbWrite(16'h1010, 32'h1, "R5 sq2 deleted");
    // R8 with SQ2 gone only SQ1 wakes: make CQ1 full again (head 2, tail 2 -> tail 1)
    advTail(1); advTail(1);
    dbWrite(16'h100C, 32'h0, "R8 cq1 wake one bound");

    // R11 disable clears everything
    @(negedge clk);
    ctrlEnable = 1'b0;
    @(negedge clk);
    for (int q = 0; q < NQ; q++) begin
      okS[q] = 0; okC[q] = 0; mTail[q] = 0; mHead[q] = 0; mCqTail[q] = 0;
    end
    readBack(0, "R11 q0 cleared");
    readBack(1, "R11 q1 cleared");
    dbWrite(16'h1000, 32'h1, "R11 write while disabled");
    readBack(0, "R11 q0 after write");

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule